// File: doc/BRIEF.md
# External Bus Cycle Sequencer with Wait Insertion

This block steps through the phases of a single external bus access: a first phase T1, a second phase T2 in multiplexed address/data mode, any number of TW wait phases, and then a return to idle with a one-clock completion pulse. A requester raises `start` with a direction flag, an address, write data and a mode select. The block captures these values and drives the address latch enable, read and write strobes, the captured address and write data, and the current phase code. It also forwards the bus clock as a clock reference for external devices.

External devices stretch an access with the active-low `wait_n` pin, which runs asynchronously to the bus clock. The block resynchronises the pin and then checks it at a point that depends on the mode. In multiplexed mode it checks on the falling clock edge inside T2 and each TW. In separate mode it checks on the rising edge that closes T1 and each TW. A limit on the number of wait phases keeps a stuck pin from holding the bus forever.

If a request arrives while an access is running, one such request is kept and starts as soon as the sequencer is idle again.

Top module: `ebus_cycle_seq`

## Requirements
- R1: Asynchronous reset (`rst_n` low) sets `bus_state` to idle (code 0) and forces `ale`, `rd_stb`, `wr_stb` and `done` low. This also applies when reset arrives in the middle of an access.
- R2: `start` is accepted only at a rising edge where the sequencer is idle. That edge moves `bus_state` to T1 (code 1) and captures `rw`, `mode`, `addr` and `wdata`. Changes on those inputs during the access have no effect on that access.
- R3: In multiplexed mode (`mode`=1), an access with no wait runs T1 for one clock and T2 (code 2) for one clock, then returns to idle. `ale` is high in T1 only, and the strobe is active in T2 and TW (code 3).
- R4: In separate mode (`mode`=0), an access with no wait runs T1 for one clock, then returns to idle. The strobe is active in T1 and TW, and `ale` stays low.
- R5: `wait_n` is active low and passes through a two-flop synchronizer. A level driven just after rising edge k reaches the decision logic only after rising edge k+2.
- R6: Multiplexed wait sampling happens on the falling edge inside T2 and each TW. If `wait_n` is held low from before the access and driven high just after rising edge k (the accepting edge is edge 0), the access contains k+1 TW phases.
- R7: Separate wait sampling happens at the rising edge that ends T1 or a TW. Under the same stimulus as R6, the access contains k+2 TW phases.
- R8: An access never contains more than MAX_WAITS (default 16) TW phases. A wait that stays low ends the access after exactly MAX_WAITS TW phases.
- R9: `done` is high for exactly one clock, in the first idle cycle after the last phase of an access.
- R10: One `start` that arrives while busy is held and begins its access (T1) one clock after the `done` cycle, with the values captured when it arrived. A `start` is ignored while a request is already held.
- R11: For `rw`=0 the strobe is `rd_stb`. For `rw`=1 the strobe is `wr_stb`, and `wdata_out` carries the captured write data. `addr_out` holds the captured address throughout the access.
- R12: `clk_out` follows `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Access request |
| rw | input | 1 | 1 = write, 0 = read |
| mode | input | 1 | 1 = multiplexed, 0 = separate |
| addr | input | AW | Access address |
| wdata | input | DW | Write data |
| wait_n | input | 1 | Asynchronous wait request, active low |
| clk_out | output | 1 | Clock reference for external devices |
| bus_state | output | 2 | 0 idle, 1 T1, 2 T2, 3 TW |
| addr_out | output | AW | Captured address |
| wdata_out | output | DW | Captured write data |
| ale | output | 1 | Address latch enable (multiplexed T1) |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| done | output | 1 | One-clock end-of-access pulse |

## Verification
The assertions rely on three conditions: reset is applied before the first access, `start` is the only way a new access begins, and the latched mode governs the whole access. The bench keeps to these conditions. It changes every input 2 ns after a rising edge, so the synchronizer and the falling-edge sampler never see a change near their capture edge. Between accesses it holds `wait_n` high for three clocks, so no wait level left over from the previous access reaches the next one.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
   typedef enum logic [1:0] {
      BS_IDLE = 2'd0,
      BS_T1   = 2'd1,
      BS_T2   = 2'd2,
      BS_TW   = 2'd3
   } bus_st_e;
endpackage

// File: rtl/ebus_sync.sv
module ebus_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("ebus_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ebus_wait_pick.sv
module ebus_wait_pick #(
   parameter bit MUX_SUPPORT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wait_act,
   input  logic mode_mux,
   output logic wait_hit
);
   generate
      if (MUX_SUPPORT) begin : g_fall
         logic fall_q;
         always_ff @(negedge clk or negedge rst_n)
            if (!rst_n) fall_q <= 1'b0;
            else        fall_q <= wait_act;
         assign wait_hit = mode_mux ? fall_q : wait_act;
      end else begin : g_rise_only
         assign wait_hit = wait_act;
      end
   endgenerate
endmodule

// File: rtl/ebus_strobe.sv
module ebus_strobe
   import ebus_pkg::*;
(
   input  bus_st_e st,
   input  logic    mode_mux,
   input  logic    rw_wr,
   output logic    ale,
   output logic    rd_stb,
   output logic    wr_stb
);
   logic window;

   always_comb begin
      if (mode_mux) window = (st == BS_T2) || (st == BS_TW);
      else          window = (st == BS_T1) || (st == BS_TW);
      ale    = mode_mux && (st == BS_T1);
      rd_stb = window && !rw_wr;
      wr_stb = window && rw_wr;
   end
endmodule

// File: rtl/ebus_fsm.sv
module ebus_fsm
   import ebus_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 16,
   parameter int MAX_WAITS = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          rw,
   input  logic          mode,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic          wait_hit,
   output bus_st_e       st_q,
   output logic          mode_q,
   output logic          rw_q,
   output logic [AW-1:0] addr_q,
   output logic [DW-1:0] wdata_q,
   output logic          done_q
);
   localparam int             CW   = $clog2(MAX_WAITS + 1);
   localparam logic [CW-1:0]  CMAX = CW'(MAX_WAITS);

   bus_st_e       st_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic          fin;
   logic          pend_q, p_mode, p_rw;
   logic [AW-1:0] p_addr;
   logic [DW-1:0] p_wdata;
   logic          take;

   assign take = (st_q == BS_IDLE) && (pend_q || start);

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      fin   = 1'b0;
      unique case (st_q)
         BS_IDLE: if (take) begin
            st_d  = BS_T1;
            cnt_d = '0;
         end
         BS_T1: begin
            if (mode_q) st_d = BS_T2;
            else if (wait_hit) begin
               st_d  = BS_TW;
               cnt_d = CW'(1);
            end else fin = 1'b1;
         end
         BS_T2: begin
            if (wait_hit) begin
               st_d  = BS_TW;
               cnt_d = CW'(1);
            end else fin = 1'b1;
         end
         BS_TW: begin
            if (wait_hit && (cnt_q < CMAX)) cnt_d = cnt_q + CW'(1);
            else fin = 1'b1;
         end
         default: st_d = BS_IDLE;
      endcase
      if (fin) st_d = BS_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= BS_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
         mode_q  <= 1'b0;
         rw_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         pend_q  <= 1'b0;
         p_mode  <= 1'b0;
         p_rw    <= 1'b0;
         p_addr  <= '0;
         p_wdata <= '0;
      end else begin
         st_q   <= st_d;
         cnt_q  <= cnt_d;
         done_q <= fin;
         if (take) begin
            pend_q <= 1'b0;
            if (pend_q) begin
               mode_q  <= p_mode;
               rw_q    <= p_rw;
               addr_q  <= p_addr;
               wdata_q <= p_wdata;
            end else begin
               mode_q  <= mode;
               rw_q    <= rw;
               addr_q  <= addr;
               wdata_q <= wdata;
            end
         end else if ((st_q != BS_IDLE) && start && !pend_q) begin
            pend_q  <= 1'b1;
            p_mode  <= mode;
            p_rw    <= rw;
            p_addr  <= addr;
            p_wdata <= wdata;
         end
      end
   end
endmodule

// File: rtl/ebus_cycle_seq.sv
module ebus_cycle_seq
   import ebus_pkg::*;
#(
   parameter int AW          = 16,
   parameter int DW          = 16,
   parameter int MAX_WAITS   = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit MUX_SUPPORT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          rw,
   input  logic          mode,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic          wait_n,
   output logic          clk_out,
   output logic [1:0]    bus_state,
   output logic [AW-1:0] addr_out,
   output logic [DW-1:0] wdata_out,
   output logic          ale,
   output logic          rd_stb,
   output logic          wr_stb,
   output logic          done
);
   generate
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("ebus_cycle_seq: AW and DW must be positive");
      end
      if (MAX_WAITS < 1) begin : g_bad_limit
         $error("ebus_cycle_seq: MAX_WAITS must be at least 1");
      end
   endgenerate

   logic    wait_sync_n;
   logic    wait_hit;
   logic    mode_q;
   logic    rw_q;
   bus_st_e st_q;

   ebus_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (wait_n),
      .q     (wait_sync_n)
   );

   ebus_wait_pick #(.MUX_SUPPORT(MUX_SUPPORT)) i_pick (
      .clk      (clk),
      .rst_n    (rst_n),
      .wait_act (~wait_sync_n),
      .mode_mux (mode_q),
      .wait_hit (wait_hit)
   );

   ebus_fsm #(.AW(AW), .DW(DW), .MAX_WAITS(MAX_WAITS)) i_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .rw       (rw),
      .mode     (mode),
      .addr     (addr),
      .wdata    (wdata),
      .wait_hit (wait_hit),
      .st_q     (st_q),
      .mode_q   (mode_q),
      .rw_q     (rw_q),
      .addr_q   (addr_out),
      .wdata_q  (wdata_out),
      .done_q   (done)
   );

   ebus_strobe i_strobe (
      .st       (st_q),
      .mode_mux (mode_q),
      .rw_wr    (rw_q),
      .ale      (ale),
      .rd_stb   (rd_stb),
      .wr_stb   (wr_stb)
   );

   assign bus_state = st_q;
   assign clk_out   = clk;
endmodule

// File: rtl/ebus_cycle_seq_chk.sv
module ebus_cycle_seq_chk
   import ebus_pkg::*;
#(
   parameter int AW        = 16,
   parameter int MAX_WAITS = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    bus_state,
   input logic          mode_q,
   input logic [AW-1:0] addr_out,
   input logic          ale,
   input logic          rd_stb,
   input logic          wr_stb,
   input logic          done
);
   localparam int RW = $clog2(MAX_WAITS + 2);
   logic [RW-1:0] tw_run;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) tw_run <= '0;
      else if (bus_state == BS_TW) tw_run <= tw_run + RW'(1);
      else tw_run <= '0;

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_state == BS_IDLE) |-> (!ale && !rd_stb && !wr_stb));

   p_ale_in_t1_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (bus_state == BS_T1));

   p_sep_no_t2_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_state == BS_T2) |-> mode_q);

   p_tw_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_state == BS_TW) |-> (tw_run < RW'(MAX_WAITS)));

   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((bus_state == BS_IDLE) && ($past(bus_state) != BS_IDLE)));

   p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({rd_stb, wr_stb}) <= 1);

   p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_state != BS_IDLE) && ($past(bus_state) != BS_IDLE)) |-> $stable(addr_out));
endmodule

bind ebus_cycle_seq ebus_cycle_seq_chk #(.AW(AW), .MAX_WAITS(MAX_WAITS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_state (bus_state),
   .mode_q    (mode_q),
   .addr_out  (addr_out),
   .ale       (ale),
   .rd_stb    (rd_stb),
   .wr_stb    (wr_stb),
   .done      (done)
);

// File: tb/test_ebus_cycle_seq.sv
module test_ebus_cycle_seq;
   localparam int AW = 16;
   localparam int DW = 16;
   localparam int MAXW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0, rw = 1'b0, mode = 1'b0, wait_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic          clk_out, ale, rd_stb, wr_stb, done;
   logic [1:0]    bus_state;
   logic [AW-1:0] addr_out;
   logic [DW-1:0] wdata_out;

   int n_run = 0, n_fail = 0;

   always #4 clk = ~clk;

   ebus_cycle_seq #(.AW(AW), .DW(DW), .MAX_WAITS(MAXW)) i_ebus_cycle_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .rw(rw), .mode(mode),
      .addr(addr), .wdata(wdata), .wait_n(wait_n), .clk_out(clk_out),
      .bus_state(bus_state), .addr_out(addr_out), .wdata_out(wdata_out),
      .ale(ale), .rd_stb(rd_stb), .wr_stb(wr_stb), .done(done)
   );

   // fields: {mode, rw, wait_low, release_edge[5:0], expected_tw[4:0]}
   localparam logic [13:0] VEC [12] = '{
      {1'b0, 1'b0, 1'b0, 6'd0,  5'd0},
      {1'b1, 1'b0, 1'b0, 6'd0,  5'd0},
      {1'b0, 1'b1, 1'b1, 6'd0,  5'd2},
      {1'b1, 1'b1, 1'b1, 6'd0,  5'd1},
      {1'b0, 1'b0, 1'b1, 6'd3,  5'd5},
      {1'b1, 1'b0, 1'b1, 6'd3,  5'd4},
      {1'b1, 1'b1, 1'b1, 6'd63, 5'd16},
      {1'b0, 1'b1, 1'b1, 6'd63, 5'd16},
      {1'b1, 1'b0, 1'b1, 6'd15, 5'd16},
      {1'b0, 1'b0, 1'b1, 6'd13, 5'd15},
      {1'b1, 1'b1, 1'b1, 6'd14, 5'd15},
      {1'b0, 1'b1, 1'b1, 6'd14, 5'd16}
   };

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   function automatic int exp_state(input bit m, input int w, input int c);
      if (c == 0) return 1;
      if (m) begin
         if (c == 1) return 2;
         if (c <= w + 1) return 3;
      end else begin
         if (c <= w) return 3;
      end
      return 0;
   endfunction

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      #4;
      // R1: reset state
      chk(bus_state == 2'd0, "R1 reset state", bus_state, 0);
      chk({ale, rd_stb, wr_stb, done} == 4'b0, "R1 reset outputs", {ale, rd_stb, wr_stb, done}, 0);
      // R12: clock reference (sampled while clk is low, then high)
      chk(clk_out == clk, "R12 clk_out low phase", clk_out, clk);
      #4;
      chk(clk_out == 1'b1, "R12 clk_out high phase", clk_out, 1);
      #2;
      // R2: no start keeps idle
      repeat (3) step();
      #4;
      chk(bus_state == 2'd0 && !done, "R2 idle without start", bus_state, 0);
      step();

      // table walk
      for (int i = 0; i < 12; i++) begin
         logic [13:0] v;
         bit          vm, vr, vlow;
         int          rel, w, tw_seen, bad_seq, bad_stb, done_at, end_c;
         v = VEC[i];
         vm = v[13]; vr = v[12]; vlow = v[11]; rel = int'(v[10:5]); w = int'(v[4:0]);
         end_c = vm ? w + 2 : w + 1;
         if (vlow) begin
            wait_n = 1'b0;
            repeat (3) step();
         end
         mode = vm; rw = vr;
         addr = AW'(16'h1100 + i * 16'h0101);
         wdata = DW'(16'hA000 + i);
         start = 1'b1;
         step();
         start = 1'b0;
         mode = ~vm;                       // R2: ignored mid-access
         addr = ~addr;
         tw_seen = 0; bad_seq = 0; bad_stb = 0; done_at = -1;
         for (int c = 0; c < 40; c++) begin
            logic exp_on;
            int   es;
            if (vlow && c == rel) wait_n = 1'b1;
            #4;
            es = exp_state(vm, w, c);
            if (int'(bus_state) != es) bad_seq++;
            if (bus_state == 2'd3) tw_seen++;
            exp_on = vm ? (es == 2 || es == 3) : (es == 1 || es == 3);
            if (ale != (vm && es == 1)) bad_stb++;
            if (rd_stb != (exp_on && !vr)) bad_stb++;
            if (wr_stb != (exp_on && vr)) bad_stb++;
            if (es != 0 && addr_out != ~addr) bad_stb++;
            if (wr_stb && wdata_out != wdata) bad_stb++;
            if (done && done_at < 0) done_at = c;
            if (es == 0) break;
            step();
         end
         chk(bad_seq == 0, vm ? "R3 R2 phase sequence" : "R4 R2 phase sequence", bad_seq, 0);
         chk(tw_seen == w, vm ? "R5 R6 R8 wait phases" : "R5 R7 R8 wait phases", tw_seen, w);
         chk(bad_stb == 0, "R11 strobes address data", bad_stb, 0);
         chk(done_at == end_c, "R9 done position", done_at, end_c);
         wait_n = 1'b1;
         step();
         #4;
         chk(!done, "R9 done one clock", done, 0);
         step();
         step();
      end

      // R10: request during busy access is held
      mode = 1'b1; rw = 1'b0; addr = 16'h0A0A; start = 1'b1;
      step();
      addr = 16'h0B0B; mode = 1'b0; rw = 1'b1; wdata = 16'h5A5A;
      #4;
      chk(bus_state == 2'd1 && addr_out == 16'h0A0A, "R10 first access T1", addr_out, 16'h0A0A);
      step();
      start = 1'b0; addr = 16'h0C0C; mode = 1'b1; wdata = 16'h0;
      #4;
      chk(bus_state == 2'd2 && addr_out == 16'h0A0A, "R10 first access T2", bus_state, 2);
      step();
      #4;
      chk(bus_state == 2'd0 && done, "R10 first access done", done, 1);
      step();
      #4;
      chk(bus_state == 2'd1 && addr_out == 16'h0B0B, "R10 held access addr", addr_out, 16'h0B0B);
      chk(wr_stb && !ale && wdata_out == 16'h5A5A, "R10 held access separate write", wdata_out, 16'h5A5A);
      step();
      #4;
      chk(bus_state == 2'd0 && done, "R10 held access done", bus_state, 0);
      step();
      step();

      // R1: reset in the middle of a stretched access
      wait_n = 1'b0;
      repeat (3) step();
      mode = 1'b0; rw = 1'b0; addr = 16'h7777; start = 1'b1;
      step();
      start = 1'b0;
      repeat (4) step();
      #4;
      chk(bus_state == 2'd3, "R8 stuck wait in TW", bus_state, 3);
      #6;
      rst_n = 1'b0;
      #1;
      chk(bus_state == 2'd0 && {ale, rd_stb, wr_stb, done} == 4'b0, "R1 reset mid access", bus_state, 0);
      wait_n = 1'b1;
      step();
      rst_n = 1'b1;
      repeat (2) step();

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule